// File: doc/BRIEF.md
# Key Matrix Scanner with Watchdog Keepalive

This block walks a key matrix of columns and rows. It pulls one column low at a time and reads the rows while that column is active. A row read as low marks the key at that column and row as pressed. Each full pass over all columns gives one snapshot of the matrix. When several keys are down, the snapshot holds the key with the lowest code. A snapshot has to repeat unchanged over a set number of full passes before its key is reported. The report is a one-clock strobe together with the key's code.

The same pass counter also keeps an external watchdog alive. After every programmed number of full passes, the block emits a one-clock positive pulse. Host logic asserts a power-down request when it wants the supply to drop. From then on the block withholds the pulse, so the external watchdog times out. Key scanning goes on unaffected.

The scan period, the debounce depth and the keepalive spacing are all parameters. With the defaults, a 4 MHz clock gives a keepalive pulse about once per second.

Top module: `kpd_scanner`

## Requirements
- R1: Exactly one bit of `col_n` is low at any time. Column 0 is low out of reset. Each column stays low for DWELL_CLKS clocks, and the low bit then moves to the next column index, wrapping from NUM_COLS-1 back to 0.
- R2: The rows are sampled on the last clock of each column's dwell. A low `row_n[r]` while column c is low means key code c*NUM_ROWS + r is pressed. With the default 5x3 matrix, codes run from 0 (column 0, row 0) to 14 (column 4, row 2).
- R3: When more than one key is pressed during a pass, the snapshot for that pass is the smallest code among them.
- R4: A key is reported only after STABLE_SCANS consecutive passes give the same snapshot. The report is `key_valid` high for exactly one clock, in the cycle after the final column sample of the pass that completes the count. At the same time `key_code` shows the code, and it holds that value until the next report. A key held down is reported once.
- R5: Any change of snapshot, including a pass in which no key is pressed, restarts the count. A key pressed again after a release is therefore reported again. A press seen in fewer than STABLE_SCANS passes is never reported.
- R6: `kick` pulses high for exactly one clock after every KICK_SCANS-th completed pass, in the cycle after that pass's final column sample.
- R7: Once `pd_req` has been high on any clock edge, `kick` stays low from the next cycle until reset. Scanning and key reports carry on as before.
- R8: While `rst` is high, `col_n` has only bit 0 low, and `key_valid`, `key_code` and `kick` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| row_n | input | NUM_ROWS | Row readback, low means a key on the active column is down |
| pd_req | input | 1 | Power-down request; stops keepalive pulses until reset |
| col_n | output | NUM_COLS | Column drives, one low at a time |
| key_valid | output | 1 | One-clock strobe for a debounced key |
| key_code | output | CODE_W | Code of the last reported key |
| kick | output | 1 | Watchdog keepalive pulse, active high |

## Verification
The assertions assume that `row_n` is synchronous to `clk` and depends only on the column currently driven low. They also assume that a column dwell is at least two clocks, so that two pass ends are never adjacent. The stimulus meets both assumptions. It builds `row_n` combinationally from `col_n` and a set of pressed keys, and it changes that set and `pd_req` only on falling clock edges. Some presses are deliberately kept shorter than the debounce depth. Others are applied several at a time, or after `pd_req`, so that the ordering and withholding rules are exercised.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
    // Number of distinct key codes in a matrix of the given size.
    function automatic int key_count(input int cols, input int rows);
        return cols * rows;
    endfunction

    // Width of a counter that must hold the values 0..limit.
    function automatic int count_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction
endpackage

// File: rtl/kpd_scan_seq.sv
module kpd_scan_seq #(
    parameter int NC = 5,
    parameter int DW = 1000,
    localparam int COL_W = kpd_pkg::count_width(NC - 1),
    localparam int DW_W  = kpd_pkg::count_width(DW - 1)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [COL_W-1:0] col_idx,
    output logic             sample,
    output logic             scan_end,
    output logic [NC-1:0]    col_n
);
    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [DW_W-1:0]  dwell;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        sample   = (s_q.dwell == DW_W'(DW - 1));
        scan_end = sample && (s_q.col == COL_W'(NC - 1));
        if (sample) begin
            s_d.dwell = '0;
            s_d.col   = scan_end ? '0 : s_q.col + 1'b1;
        end else begin
            s_d.dwell = s_q.dwell + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign col_idx = s_q.col;

    for (genvar g = 0; g < NC; g++) begin : g_col
        assign col_n[g] = (s_q.col != COL_W'(g));
    end

    // R1
    one_col_low_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(col_n) == NC - 1);

    // R1
    col_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample |=> $stable(col_n));
endmodule

// File: rtl/kpd_capture.sv
module kpd_capture #(
    parameter int NC = 5,
    parameter int NR = 3,
    localparam int COL_W  = kpd_pkg::count_width(NC - 1),
    localparam int ROW_W  = kpd_pkg::count_width(NR - 1),
    localparam int CODE_W = kpd_pkg::count_width(kpd_pkg::key_count(NC, NR) - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COL_W-1:0]  col_idx,
    input  logic [NR-1:0]     row_n,
    input  logic              sample,
    input  logic              scan_end,
    output logic              snap_hit,
    output logic [CODE_W-1:0] snap_code
);
    typedef struct packed {
        logic              hit;
        logic [CODE_W-1:0] code;
    } cap_t;

    cap_t c_d, c_q;
    logic              found;
    logic [ROW_W-1:0]  row_sel;
    logic [CODE_W-1:0] cand_code;

    always_comb begin
        found   = 1'b0;
        row_sel = '0;
        for (int r = NR - 1; r >= 0; r--) begin
            if (!row_n[r]) begin
                found   = 1'b1;
                row_sel = ROW_W'(r);
            end
        end
        cand_code = CODE_W'(col_idx) * CODE_W'(NR) + CODE_W'(row_sel);

        snap_hit  = c_q.hit || (sample && found);
        snap_code = c_q.hit ? c_q.code : cand_code;

        c_d = c_q;
        if (sample && found && !c_q.hit) begin
            c_d.hit  = 1'b1;
            c_d.code = cand_code;
        end
        if (scan_end) c_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    // R3
    first_hit_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (c_q.hit && !scan_end) |=> (c_q.hit && $stable(c_q.code)));
endmodule

// File: rtl/kpd_debounce.sv
module kpd_debounce #(
    parameter int DB     = 3,
    parameter int CODE_W = 4,
    localparam int CNT_W = kpd_pkg::count_width(DB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_end,
    input  logic              snap_hit,
    input  logic [CODE_W-1:0] snap_code,
    output logic              key_valid,
    output logic [CODE_W-1:0] key_code
);
    typedef struct packed {
        logic              prev_hit;
        logic [CODE_W-1:0] prev_code;
        logic [CNT_W-1:0]  cnt;
        logic              reported;
        logic              valid;
        logic [CODE_W-1:0] code;
    } deb_t;

    deb_t b_d, b_q;
    logic same;

    always_comb begin
        b_d       = b_q;
        b_d.valid = 1'b0;
        same      = (snap_hit == b_q.prev_hit) &&
                    (!snap_hit || snap_code == b_q.prev_code);
        if (scan_end) begin
            if (!same) begin
                b_d.cnt      = CNT_W'(1);
                b_d.reported = 1'b0;
            end else if (b_q.cnt < CNT_W'(DB)) begin
                b_d.cnt = b_q.cnt + 1'b1;
            end
            b_d.prev_hit  = snap_hit;
            b_d.prev_code = snap_code;
            if (snap_hit && !b_d.reported && b_d.cnt >= CNT_W'(DB)) begin
                b_d.valid    = 1'b1;
                b_d.code     = snap_code;
                b_d.reported = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) b_q <= '0;
        else     b_q <= b_d;
    end

    assign key_valid = b_q.valid;
    assign key_code  = b_q.code;

    // R4
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        key_valid |=> !key_valid);

    // R4
    valid_after_scan_chk: assert property (@(posedge clk) disable iff (rst)
        key_valid |-> $past(scan_end));

    // R4
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !key_valid |-> $stable(key_code));
endmodule

// File: rtl/kpd_keepalive.sv
module kpd_keepalive #(
    parameter int KS = 800,
    localparam int KS_W = kpd_pkg::count_width(KS - 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic scan_end,
    input  logic pd_req,
    output logic kick
);
    typedef struct packed {
        logic [KS_W-1:0] scans;
        logic            pd_seen;
        logic            kick;
    } ka_t;

    ka_t k_d, k_q;
    logic pd_now;

    always_comb begin
        k_d         = k_q;
        k_d.kick    = 1'b0;
        pd_now      = k_q.pd_seen || pd_req;
        k_d.pd_seen = pd_now;
        if (scan_end) begin
            if (k_q.scans == KS_W'(KS - 1)) begin
                k_d.scans = '0;
                k_d.kick  = !pd_now;
            end else begin
                k_d.scans = k_q.scans + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) k_q <= '0;
        else     k_q <= k_d;
    end

    assign kick = k_q.kick;

    // R6
    kick_single_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> !kick);

    // R6
    kick_after_scan_chk: assert property (@(posedge clk) disable iff (rst)
        kick |-> $past(scan_end));

    // R7
    pd_blocks_next_chk: assert property (@(posedge clk) disable iff (rst)
        pd_req |=> !kick);

    // R7
    pd_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        k_q.pd_seen |-> !kick);
endmodule

// File: rtl/kpd_scanner.sv
module kpd_scanner #(
    parameter int NUM_COLS     = 5,
    parameter int NUM_ROWS     = 3,
    parameter int DWELL_CLKS   = 1000,
    parameter int STABLE_SCANS = 3,
    parameter int KICK_SCANS   = 800,
    localparam int COL_W  = kpd_pkg::count_width(NUM_COLS - 1),
    localparam int CODE_W = kpd_pkg::count_width(kpd_pkg::key_count(NUM_COLS, NUM_ROWS) - 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_ROWS-1:0] row_n,
    input  logic                pd_req,
    output logic [NUM_COLS-1:0] col_n,
    output logic                key_valid,
    output logic [CODE_W-1:0]   key_code,
    output logic                kick
);
    logic [COL_W-1:0]  col_idx;
    logic              sample;
    logic              scan_end;
    logic              snap_hit;
    logic [CODE_W-1:0] snap_code;

    kpd_scan_seq #(.NC(NUM_COLS), .DW(DWELL_CLKS)) u_seq (
        .clk(clk), .rst(rst), .col_idx(col_idx), .sample(sample),
        .scan_end(scan_end), .col_n(col_n)
    );

    kpd_capture #(.NC(NUM_COLS), .NR(NUM_ROWS)) u_cap (
        .clk(clk), .rst(rst), .col_idx(col_idx), .row_n(row_n),
        .sample(sample), .scan_end(scan_end),
        .snap_hit(snap_hit), .snap_code(snap_code)
    );

    kpd_debounce #(.DB(STABLE_SCANS), .CODE_W(CODE_W)) u_deb (
        .clk(clk), .rst(rst), .scan_end(scan_end), .snap_hit(snap_hit),
        .snap_code(snap_code), .key_valid(key_valid), .key_code(key_code)
    );

    kpd_keepalive #(.KS(KICK_SCANS)) u_ka (
        .clk(clk), .rst(rst), .scan_end(scan_end), .pd_req(pd_req),
        .kick(kick)
    );

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!key_valid && !kick));
endmodule

// File: tb/kpd_scanner_test.sv
module kpd_scanner_test;
    localparam int NC = 5, NR = 3, DW = 4, DB = 3, KS = 6;
    localparam int SCAN = NC * DW;

    logic clk = 1'b0, rst = 1'b1, pd_req = 1'b0;
    logic [NR-1:0] row_n;
    logic [NC-1:0] col_n;
    logic key_valid, kick;
    logic [3:0] key_code;
    logic [NC*NR-1:0] pressed = '0;

    always #10 clk = ~clk;

    kpd_scanner #(.NUM_COLS(NC), .NUM_ROWS(NR), .DWELL_CLKS(DW),
                  .STABLE_SCANS(DB), .KICK_SCANS(KS)) uut (
        .clk(clk), .rst(rst), .row_n(row_n), .pd_req(pd_req),
        .col_n(col_n), .key_valid(key_valid), .key_code(key_code), .kick(kick)
    );

    // Key matrix: a pressed key pulls its row low while its column is low.
    always_comb begin
        row_n = '1;
        for (int c = 0; c < NC; c++)
            for (int r = 0; r < NR; r++)
                if (!col_n[c] && pressed[c*NR + r]) row_n[r] = 1'b0;
    end

    // Behavioural reference model, advanced on every rising edge.
    int n, acc_hit, acc_code, prev_hit, prev_code, cnt, rep, scans, pd_seen;
    int exp_col, exp_valid, exp_code, exp_kick;

    always @(posedge clk) begin
        if (rst) begin
            n = 0; acc_hit = 0; acc_code = 0; prev_hit = 0; prev_code = 0;
            cnt = 0; rep = 0; scans = 0; pd_seen = 0;
            exp_col = 0; exp_valid = 0; exp_code = 0; exp_kick = 0;
        end else begin
            int c, s_hit, s_code;
            c = (n / DW) % NC;
            exp_valid = 0;
            exp_kick = 0;
            if (n % DW == DW - 1)
                for (int r = 0; r < NR; r++)
                    if (pressed[c*NR + r] && !acc_hit) begin
                        acc_hit = 1; acc_code = c*NR + r;
                    end
            if (n % SCAN == SCAN - 1) begin
                s_hit = acc_hit; s_code = acc_code; acc_hit = 0;
                if (s_hit != prev_hit || (s_hit && s_code != prev_code)) begin
                    cnt = 1; rep = 0;
                end else if (cnt < DB) cnt++;
                prev_hit = s_hit; prev_code = s_code;
                if (s_hit && !rep && cnt >= DB) begin
                    exp_valid = 1; exp_code = s_code; rep = 1;
                end
                scans++;
                if (scans == KS) begin
                    scans = 0;
                    if (!(pd_seen || pd_req)) exp_kick = 1;
                end
            end
            if (pd_req) pd_seen = 1;
            n++;
            exp_col = (n / DW) % NC;
        end
    end

    int checks = 0, fails = 0, strobes = 0, kicks = 0, last_code = 0;
    string key_req = "R4";
    string kick_req = "R6";

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk(col_n == ~(NC'(1) << exp_col), "R1", "col_n", int'(col_n),
                int'(~(NC'(1) << exp_col)));
            chk(key_valid == exp_valid[0], key_req, "key_valid",
                int'(key_valid), exp_valid);
            if (exp_valid != 0)
                chk(key_code == exp_code[3:0], key_req, "key_code",
                    int'(key_code), exp_code);
            chk(kick == exp_kick[0], kick_req, "kick", int'(kick), exp_kick);
            if (key_valid) begin strobes++; last_code = int'(key_code); end
            if (kick) kicks++;
        end
    end

    task automatic run_scans(input int k);
        repeat (k * SCAN) @(negedge clk);
    endtask

    task automatic hold_key(input int code, input int k, input string req);
        key_req = req;
        strobes = 0;
        pressed = '0;
        pressed[code] = 1'b1;
        run_scans(k);
        chk(strobes == 1, req, "strobe count", strobes, 1);
        chk(last_code == code, req, "reported code", last_code, code);
        pressed = '0;
        run_scans(4);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                // R8 reset state
                chk(col_n == 5'b11110, "R8", "col_n in reset", int'(col_n), 30);
                chk(key_valid == 1'b0, "R8", "key_valid in reset", int'(key_valid), 0);
                chk(key_code == 4'd0, "R8", "key_code in reset", int'(key_code), 0);
                chk(kick == 1'b0, "R8", "kick in reset", int'(kick), 0);
                rst = 1'b0;

                // R6: 13 idle passes give two keepalive pulses
                kicks = 0;
                strobes = 0;
                run_scans(13);
                chk(kicks == 2, "R6", "kick count", kicks, 2);
                chk(strobes == 0, "R4", "idle strobes", strobes, 0);

                // R2 single key, held long: one report
                repeat (7) @(negedge clk);
                hold_key(7, 8, "R2");

                // R5 same key again after release
                hold_key(7, 5, "R5");

                // R5 short press of one pass is ignored
                key_req = "R5";
                strobes = 0;
                pressed = '0; pressed[9] = 1'b1;
                run_scans(1);
                pressed = '0;
                run_scans(4);
                chk(strobes == 0, "R5", "glitch strobes", strobes, 0);

                // R3 several keys: lowest wins
                key_req = "R3";
                strobes = 0;
                pressed = '0; pressed[4] = 1'b1; pressed[11] = 1'b1; pressed[13] = 1'b1;
                run_scans(6);
                chk(strobes == 1, "R3", "strobe count", strobes, 1);
                chk(last_code == 4, "R3", "lowest code", last_code, 4);
                pressed = '0;
                run_scans(4);

                // R2 corner codes
                hold_key(0, 5, "R2");
                hold_key(14, 5, "R2");

                // R7 power-down request withholds the keepalive only
                kick_req = "R7";
                pd_req = 1'b1;
                @(negedge clk);
                pd_req = 1'b0;
                kicks = 0;
                hold_key(5, 16, "R7");
                chk(kicks == 0, "R7", "kicks after power-down", kicks, 0);
            end
            begin
                repeat (100000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog timeout");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule